// File: doc/BRIEF.md
# Direct-Mapped Write-Back Cache with DMA Bus Snooping

This block is a small direct-mapped write-back data cache for one processor. The processor and a DMA engine share a single memory bus. Each line is one data word. Each line holds a valid flag, a dirty flag, a tag and the data word. A processor write that hits only updates the cache and marks the line dirty. A miss that evicts a dirty line first writes the victim back to memory, then reads the new word. The cache asks for the bus with `bus_req`. It drives the bus only while the arbiter holds `bus_grant` high.

The line store has a second, independent read port that watches DMA bus cycles whenever the cache is not the bus master. On a DMA read of a line the cache holds dirty, the cache intervenes in the same cycle and supplies the line, so the memory copy is not used. On a DMA write that hits a cached line, clean or dirty, the cache purges that line, because the DMA data supersedes it. The snoop update always wins: a processor request presented in a cycle that has a snoop hit is held off for that cycle.

The processor holds `cpu_req` and its operands steady until it sees `cpu_ready`. A word address splits into an index (low `IDX_W` bits) and a tag (the remaining high bits). Memory answers a granted bus cycle with a one-cycle `mem_ack` pulse. The cache keeps `bus_cyc_o` high until that pulse arrives.

Top module: `dma_snoop_cache`

## Requirements
- R1: After reset every line is invalid. `cpu_ready`, `bus_req`, `bus_cyc_o` and `snoop_intervene` are low. The first processor access and any DMA read behave as misses.
- R2: A processor read that hits raises `cpu_ready` in the cycle of the request, with the cached word on `cpu_rdata`. `cpu_ready` is never high without `cpu_req`.
- R3: A processor write that hits completes in the request cycle, stores `cpu_wdata` and marks the line dirty.
- R4: A miss whose victim is invalid or clean issues one bus read (`bus_we_o`=0) of the requested address and fills the line clean. With an immediate grant, the request completes 3 cycles after it was presented.
- R5: A miss whose victim is dirty first issues a bus write (`bus_we_o`=1) of the victim word to its address {victim tag, index}, then the refill read. With an immediate grant, the request completes 5 cycles after it was presented.
- R6: While `bus_grant` is low, `bus_cyc_o`, `bus_we_o`, `bus_addr_o` and `bus_wdata_o` are all zero. While a write-back or refill is pending, `bus_req` stays high. DMA inputs are ignored while `bus_grant` is high.
- R7: A DMA read (`dma_cyc`=1, `dma_we`=0) that misses the cache, or hits a clean line, leaves `snoop_intervene` low and changes no cache state.
- R8: A DMA read that hits a dirty line raises `snoop_intervene` in the same cycle and places the line word on `snoop_data`. The line stays cached and dirty.
- R9: A DMA write (`dma_we`=1) to an address the cache does not hold changes no cache state, so held lines still hit.
- R10: A DMA write that hits a clean line invalidates it. The next processor access to that address misses and returns the new memory word.
- R11: A DMA write that hits a dirty line invalidates it and discards the dirty word. No write-back of that word is ever issued.
- R12: When a snoop hit and a processor request fall in the same cycle, `cpu_ready` stays low for that cycle. The request is served afterwards.
- R13: If a dirty victim waiting for the bus is purged by a DMA write, the pending miss skips its write-back and goes straight to the refill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor access request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Processor word address |
| cpu_wdata | input | DATA_W | Processor write data |
| cpu_ready | output | 1 | Access completes at this clock edge |
| cpu_rdata | output | DATA_W | Read data, valid with `cpu_ready` |
| bus_req | output | 1 | Cache asks for bus mastership |
| bus_grant | input | 1 | Cache is bus master |
| bus_cyc_o | output | 1 | Cache bus cycle active |
| bus_we_o | output | 1 | Cache bus cycle is a write |
| bus_addr_o | output | ADDR_W | Cache bus address |
| bus_wdata_o | output | DATA_W | Cache bus write data |
| mem_ack | input | 1 | Memory completes the cache bus cycle |
| mem_rdata | input | DATA_W | Memory read data, valid with `mem_ack` |
| dma_cyc | input | 1 | DMA bus cycle active |
| dma_we | input | 1 | DMA cycle writes memory |
| dma_addr | input | ADDR_W | DMA bus address |
| snoop_intervene | output | 1 | Cache supplies the data of the current DMA read |
| snoop_data | output | DATA_W | Intervention data, zero otherwise |

## Verification
Hit results and snoop responses are combinational. The bench samples `cpu_ready`, `cpu_rdata`, `snoop_intervene` and `snoop_data` one nanosecond after the inputs are driven in the low clock phase. A purge takes effect at the next rising edge, so its effect is checked on the following access. Miss latency is the number of falling edges between the request and `cpu_ready`. With the bench's grant given at the falling edge after `bus_req` and memory answering one cycle after it sees a cycle, the expected latency is 0 for a hit, 3 for a clean miss and 5 for a dirty miss. Memory contents and the count of bus writes show whether a write-back happened or was suppressed.

// File: rtl/dsc_pkg.sv
package dsc_pkg;

   typedef enum logic [1:0] {
      CS_IDLE  = 2'd0,
      CS_WBACK = 2'd1,
      CS_FILL  = 2'd2
   } ctl_state_e;

   // Latency of each access class with an immediate grant
   localparam int LAT_HIT        = 0;
   localparam int LAT_CLEAN_MISS = 3;
   localparam int LAT_DIRTY_MISS = 5;

endpackage

// File: rtl/dsc_line_store.sv
module dsc_line_store #(
   parameter int IDX_W  = 3,
   parameter int TAG_W  = 7,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   // processor read port
   input  logic [IDX_W-1:0]  cpu_idx,
   output logic              cpu_valid,
   output logic              cpu_dirty,
   output logic [TAG_W-1:0]  cpu_tag,
   output logic [DATA_W-1:0] cpu_data,
   // snoop read port
   input  logic [IDX_W-1:0]  snp_idx,
   output logic              snp_valid,
   output logic              snp_dirty,
   output logic [TAG_W-1:0]  snp_tag,
   output logic [DATA_W-1:0] snp_data,
   // snoop purge (highest priority)
   input  logic              purge_en,
   input  logic [IDX_W-1:0]  purge_idx,
   // controller update
   input  logic              upd_en,
   input  logic [IDX_W-1:0]  upd_idx,
   input  logic              upd_valid,
   input  logic              upd_dirty,
   input  logic              upd_tag_en,
   input  logic [TAG_W-1:0]  upd_tag,
   input  logic              upd_data_en,
   input  logic [DATA_W-1:0] upd_data
);

   localparam int LINES = 1 << IDX_W;

   logic              valid_q [LINES];
   logic              dirty_q [LINES];
   logic [TAG_W-1:0]  tag_q   [LINES];
   logic [DATA_W-1:0] data_q  [LINES];

   for (genvar i = 0; i < LINES; i++) begin : g_line
      logic hit_purge;
      logic hit_upd;
      assign hit_purge = purge_en && (purge_idx == IDX_W'(i));
      assign hit_upd   = upd_en   && (upd_idx   == IDX_W'(i));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            valid_q[i] <= 1'b0;
            dirty_q[i] <= 1'b0;
            tag_q[i]   <= '0;
            data_q[i]  <= '0;
         end else if (hit_purge) begin
            valid_q[i] <= 1'b0;
            dirty_q[i] <= 1'b0;
         end else if (hit_upd) begin
            valid_q[i] <= upd_valid;
            dirty_q[i] <= upd_dirty;
            if (upd_tag_en)  tag_q[i]  <= upd_tag;
            if (upd_data_en) data_q[i] <= upd_data;
         end
      end
   end

   assign cpu_valid = valid_q[cpu_idx];
   assign cpu_dirty = dirty_q[cpu_idx];
   assign cpu_tag   = tag_q[cpu_idx];
   assign cpu_data  = data_q[cpu_idx];

   assign snp_valid = valid_q[snp_idx];
   assign snp_dirty = dirty_q[snp_idx];
   assign snp_tag   = tag_q[snp_idx];
   assign snp_data  = data_q[snp_idx];

endmodule

// File: rtl/dsc_snoop_unit.sv
module dsc_snoop_unit #(
   parameter int ADDR_W = 10,
   parameter int IDX_W  = 3,
   parameter int DATA_W = 16
) (
   input  logic                    dma_cyc,
   input  logic                    dma_we,
   input  logic [ADDR_W-1:0]       dma_addr,
   input  logic                    bus_grant,
   output logic [IDX_W-1:0]        snp_idx,
   input  logic                    snp_valid,
   input  logic                    snp_dirty,
   input  logic [ADDR_W-IDX_W-1:0] snp_tag,
   input  logic [DATA_W-1:0]       snp_data,
   output logic                    snoop_hit,
   output logic                    snoop_intervene,
   output logic [DATA_W-1:0]       snoop_data,
   output logic                    purge_en,
   output logic [IDX_W-1:0]        purge_idx
);

   logic observe;
   logic tag_match;

   assign snp_idx   = dma_addr[IDX_W-1:0];
   // A cycle counts only when another master owns the bus
   assign observe   = dma_cyc && !bus_grant;
   assign tag_match = (snp_tag == dma_addr[ADDR_W-1:IDX_W]);
   assign snoop_hit = observe && snp_valid && tag_match;

   assign snoop_intervene = snoop_hit && !dma_we && snp_dirty;
   assign snoop_data      = snoop_intervene ? snp_data : '0;

   assign purge_en  = snoop_hit && dma_we;
   assign purge_idx = snp_idx;

endmodule

// File: rtl/dsc_ctrl.sv
module dsc_ctrl
   import dsc_pkg::*;
#(
   parameter int ADDR_W = 10,
   parameter int IDX_W  = 3,
   parameter int DATA_W = 16
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    cpu_req,
   input  logic                    cpu_we,
   input  logic [ADDR_W-1:0]       cpu_addr,
   input  logic [DATA_W-1:0]       cpu_wdata,
   output logic                    cpu_ready,
   output logic [DATA_W-1:0]       cpu_rdata,
   input  logic                    snoop_hit,
   output logic [IDX_W-1:0]        cpu_idx,
   input  logic                    ln_valid,
   input  logic                    ln_dirty,
   input  logic [ADDR_W-IDX_W-1:0] ln_tag,
   input  logic [DATA_W-1:0]       ln_data,
   output logic                    upd_en,
   output logic [IDX_W-1:0]        upd_idx,
   output logic                    upd_valid,
   output logic                    upd_dirty,
   output logic                    upd_tag_en,
   output logic [ADDR_W-IDX_W-1:0] upd_tag,
   output logic                    upd_data_en,
   output logic [DATA_W-1:0]       upd_data,
   output logic                    bus_req,
   input  logic                    bus_grant,
   output logic                    cyc_raw,
   output logic                    we_raw,
   output logic [ADDR_W-1:0]       addr_raw,
   output logic [DATA_W-1:0]       wdata_raw,
   input  logic                    mem_ack,
   input  logic [DATA_W-1:0]       mem_rdata
);

   localparam int TAG_W = ADDR_W - IDX_W;

   ctl_state_e       state_q, state_d;
   logic [TAG_W-1:0] req_tag;
   logic             lookup_hit;
   logic             victim_dirty;

   assign cpu_idx      = cpu_addr[IDX_W-1:0];
   assign req_tag      = cpu_addr[ADDR_W-1:IDX_W];
   assign lookup_hit   = ln_valid && (ln_tag == req_tag);
   assign victim_dirty = ln_valid && ln_dirty;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= CS_IDLE;
      else        state_q <= state_d;
   end

   always_comb begin
      state_d     = state_q;
      cpu_ready   = 1'b0;
      upd_en      = 1'b0;
      upd_idx     = cpu_idx;
      upd_valid   = 1'b1;
      upd_dirty   = 1'b0;
      upd_tag_en  = 1'b0;
      upd_tag     = req_tag;
      upd_data_en = 1'b0;
      upd_data    = cpu_wdata;
      cyc_raw     = 1'b0;
      we_raw      = 1'b0;
      addr_raw    = cpu_addr;
      wdata_raw   = '0;
      unique case (state_q)
         CS_IDLE: begin
            // a snoop hit owns the line store this cycle
            if (cpu_req && !snoop_hit) begin
               if (lookup_hit) begin
                  cpu_ready = 1'b1;
                  if (cpu_we) begin
                     upd_en      = 1'b1;
                     upd_dirty   = 1'b1;
                     upd_data_en = 1'b1;
                  end
               end else if (victim_dirty) begin
                  state_d = CS_WBACK;
               end else begin
                  state_d = CS_FILL;
               end
            end
         end
         CS_WBACK: begin
            if (!victim_dirty) begin
               // victim purged while waiting: nothing to save
               state_d = CS_FILL;
            end else if (bus_grant) begin
               cyc_raw   = 1'b1;
               we_raw    = 1'b1;
               addr_raw  = {ln_tag, cpu_idx};
               wdata_raw = ln_data;
               if (mem_ack) begin
                  upd_en    = 1'b1;
                  upd_dirty = 1'b0;
                  state_d   = CS_FILL;
               end
            end
         end
         CS_FILL: begin
            if (bus_grant) begin
               cyc_raw = 1'b1;
               if (mem_ack) begin
                  upd_en      = 1'b1;
                  upd_tag_en  = 1'b1;
                  upd_data_en = 1'b1;
                  upd_data    = mem_rdata;
                  state_d     = CS_IDLE;
               end
            end
         end
         default: state_d = CS_IDLE;
      endcase
   end

   assign bus_req   = (state_q != CS_IDLE);
   assign cpu_rdata = cpu_ready ? ln_data : '0;

endmodule

// File: rtl/dsc_bus_drive.sv
module dsc_bus_drive #(
   parameter int ADDR_W = 10,
   parameter int DATA_W = 16
) (
   input  logic              bus_grant,
   input  logic              cyc_raw,
   input  logic              we_raw,
   input  logic [ADDR_W-1:0] addr_raw,
   input  logic [DATA_W-1:0] wdata_raw,
   output logic              bus_cyc_o,
   output logic              bus_we_o,
   output logic [ADDR_W-1:0] bus_addr_o,
   output logic [DATA_W-1:0] bus_wdata_o
);

   logic drive;

   assign drive       = bus_grant && cyc_raw;
   assign bus_cyc_o   = drive;
   assign bus_we_o    = drive && we_raw;
   assign bus_addr_o  = drive ? addr_raw : '0;
   assign bus_wdata_o = (drive && we_raw) ? wdata_raw : '0;

endmodule

// File: rtl/dma_snoop_cache.sv
module dma_snoop_cache #(
   parameter int ADDR_W = 10,
   parameter int DATA_W = 16,
   parameter int IDX_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic              cpu_ready,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic              bus_req,
   input  logic              bus_grant,
   output logic              bus_cyc_o,
   output logic              bus_we_o,
   output logic [ADDR_W-1:0] bus_addr_o,
   output logic [DATA_W-1:0] bus_wdata_o,
   input  logic              mem_ack,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic              dma_cyc,
   input  logic              dma_we,
   input  logic [ADDR_W-1:0] dma_addr,
   output logic              snoop_intervene,
   output logic [DATA_W-1:0] snoop_data
);

   localparam int TAG_W = ADDR_W - IDX_W;

   if (IDX_W < 1 || IDX_W > 10) begin : g_bad_idx
      $error("dma_snoop_cache: IDX_W out of range");
   end
   if (IDX_W >= ADDR_W) begin : g_bad_tag
      $error("dma_snoop_cache: ADDR_W must exceed IDX_W");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("dma_snoop_cache: DATA_W must be positive");
   end

   logic [IDX_W-1:0]  cpu_idx, snp_idx, purge_idx, upd_idx;
   logic              ln_valid, ln_dirty, snp_valid, snp_dirty;
   logic [TAG_W-1:0]  ln_tag, snp_tag, upd_tag;
   logic [DATA_W-1:0] ln_data, snp_data, upd_data, wdata_raw;
   logic              purge_en, snoop_hit;
   logic              upd_en, upd_valid, upd_dirty, upd_tag_en, upd_data_en;
   logic              cyc_raw, we_raw;
   logic [ADDR_W-1:0] addr_raw;

   dsc_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
      .clk        (clk),
      .rst_n      (rst_n),
      .cpu_idx    (cpu_idx),
      .cpu_valid  (ln_valid),
      .cpu_dirty  (ln_dirty),
      .cpu_tag    (ln_tag),
      .cpu_data   (ln_data),
      .snp_idx    (snp_idx),
      .snp_valid  (snp_valid),
      .snp_dirty  (snp_dirty),
      .snp_tag    (snp_tag),
      .snp_data   (snp_data),
      .purge_en   (purge_en),
      .purge_idx  (purge_idx),
      .upd_en     (upd_en),
      .upd_idx    (upd_idx),
      .upd_valid  (upd_valid),
      .upd_dirty  (upd_dirty),
      .upd_tag_en (upd_tag_en),
      .upd_tag    (upd_tag),
      .upd_data_en(upd_data_en),
      .upd_data   (upd_data)
   );

   dsc_snoop_unit #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_snoop (
      .dma_cyc        (dma_cyc),
      .dma_we         (dma_we),
      .dma_addr       (dma_addr),
      .bus_grant      (bus_grant),
      .snp_idx        (snp_idx),
      .snp_valid      (snp_valid),
      .snp_dirty      (snp_dirty),
      .snp_tag        (snp_tag),
      .snp_data       (snp_data),
      .snoop_hit      (snoop_hit),
      .snoop_intervene(snoop_intervene),
      .snoop_data     (snoop_data),
      .purge_en       (purge_en),
      .purge_idx      (purge_idx)
   );

   dsc_ctrl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .cpu_req    (cpu_req),
      .cpu_we     (cpu_we),
      .cpu_addr   (cpu_addr),
      .cpu_wdata  (cpu_wdata),
      .cpu_ready  (cpu_ready),
      .cpu_rdata  (cpu_rdata),
      .snoop_hit  (snoop_hit),
      .cpu_idx    (cpu_idx),
      .ln_valid   (ln_valid),
      .ln_dirty   (ln_dirty),
      .ln_tag     (ln_tag),
      .ln_data    (ln_data),
      .upd_en     (upd_en),
      .upd_idx    (upd_idx),
      .upd_valid  (upd_valid),
      .upd_dirty  (upd_dirty),
      .upd_tag_en (upd_tag_en),
      .upd_tag    (upd_tag),
      .upd_data_en(upd_data_en),
      .upd_data   (upd_data),
      .bus_req    (bus_req),
      .bus_grant  (bus_grant),
      .cyc_raw    (cyc_raw),
      .we_raw     (we_raw),
      .addr_raw   (addr_raw),
      .wdata_raw  (wdata_raw),
      .mem_ack    (mem_ack),
      .mem_rdata  (mem_rdata)
   );

   dsc_bus_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_drive (
      .bus_grant  (bus_grant),
      .cyc_raw    (cyc_raw),
      .we_raw     (we_raw),
      .addr_raw   (addr_raw),
      .wdata_raw  (wdata_raw),
      .bus_cyc_o  (bus_cyc_o),
      .bus_we_o   (bus_we_o),
      .bus_addr_o (bus_addr_o),
      .bus_wdata_o(bus_wdata_o)
   );

endmodule

// File: rtl/dsc_checker.sv
module dsc_checker #(
   parameter int ADDR_W = 10,
   parameter int DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cpu_req,
   input logic              cpu_ready,
   input logic              bus_req,
   input logic              bus_grant,
   input logic              bus_cyc_o,
   input logic              bus_we_o,
   input logic [ADDR_W-1:0] bus_addr_o,
   input logic [DATA_W-1:0] bus_wdata_o,
   input logic              mem_ack,
   input logic              dma_cyc,
   input logic              dma_we,
   input logic [ADDR_W-1:0] dma_addr,
   input logic              snoop_intervene,
   input logic              snoop_hit
);

   AST_READY_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_ready |-> cpu_req); // R2

   AST_BUS_QUIET_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_grant |-> (!bus_cyc_o && !bus_we_o && bus_addr_o == '0 && bus_wdata_o == '0)); // R6

   AST_FILL_AFTER_WBACK: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_cyc_o && bus_we_o && mem_ack) |=> bus_req); // R5

   AST_NO_INTERVENE_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_cyc && dma_we) |-> !snoop_intervene); // R8

   AST_PURGE_TAKES_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_cyc && !bus_grant && !dma_we && $past(dma_cyc && !bus_grant && dma_we)
       && dma_addr == $past(dma_addr)) |-> !snoop_intervene); // R11

   AST_SNOOP_STALLS_CPU: assert property (@(posedge clk) disable iff (!rst_n)
      (snoop_hit && cpu_req) |-> !cpu_ready); // R12

endmodule

bind dma_snoop_cache dsc_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .cpu_req        (cpu_req),
   .cpu_ready      (cpu_ready),
   .bus_req        (bus_req),
   .bus_grant      (bus_grant),
   .bus_cyc_o      (bus_cyc_o),
   .bus_we_o       (bus_we_o),
   .bus_addr_o     (bus_addr_o),
   .bus_wdata_o    (bus_wdata_o),
   .mem_ack        (mem_ack),
   .dma_cyc        (dma_cyc),
   .dma_we         (dma_we),
   .dma_addr       (dma_addr),
   .snoop_intervene(snoop_intervene),
   .snoop_hit      (snoop_hit)
);

// File: tb/dma_snoop_cache_tb.sv
module dma_snoop_cache_tb;

   localparam int AW = 10;
   localparam int DW = 16;
   localparam int IW = 3;
   localparam int TW = AW - IW;
   localparam int NL = 1 << IW;
   localparam int MW = 1 << AW;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic          rst_n = 1'b0;
   logic          cpu_req = 1'b0, cpu_we = 1'b0;
   logic [AW-1:0] cpu_addr = '0;
   logic [DW-1:0] cpu_wdata = '0;
   logic          cpu_ready;
   logic [DW-1:0] cpu_rdata;
   logic          bus_req, bus_grant = 1'b0;
   logic          bus_cyc_o, bus_we_o;
   logic [AW-1:0] bus_addr_o;
   logic [DW-1:0] bus_wdata_o;
   logic          mem_ack = 1'b0;
   logic [DW-1:0] mem_rdata = '0;
   logic          dma_cyc = 1'b0, dma_we = 1'b0;
   logic [AW-1:0] dma_addr = '0;
   logic [DW-1:0] dma_wdata = '0;
   logic          snoop_intervene;
   logic [DW-1:0] snoop_data;

   logic gnt_en = 1'b1;
   logic dma_active = 1'b0;
   int   checks = 0;
   int   fails = 0;
   int   wr_count;

   dma_snoop_cache #(.ADDR_W(AW), .DATA_W(DW), .IDX_W(IW)) u_dut (.*);

   // memory and bus arbiter models
   logic [DW-1:0] mem [MW];
   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < MW; i++) mem[i] <= DW'(i * 37 + 5);
         mem_ack  <= 1'b0;
         wr_count <= 0;
      end else begin
         if (bus_cyc_o && !mem_ack) begin
            mem_ack <= 1'b1;
            if (bus_we_o) begin
               mem[bus_addr_o] <= bus_wdata_o;
               wr_count <= wr_count + 1;
            end else begin
               mem_rdata <= mem[bus_addr_o];
            end
         end else begin
            mem_ack <= 1'b0;
         end
         if (dma_cyc && dma_we && !bus_grant) mem[dma_addr] <= dma_wdata;
      end
   end

   always @(negedge clk) begin
      if (!rst_n)         bus_grant <= 1'b0;
      else if (bus_grant) bus_grant <= bus_req;
      else                bus_grant <= bus_req && gnt_en && !dma_active;
   end

   // reference model
   logic          mv [NL];
   logic          md [NL];
   logic [TW-1:0] mt [NL];
   logic [DW-1:0] mdat [NL];
   logic [DW-1:0] emem [MW];

   // returns 0 hit, 1 clean miss, 2 dirty miss
   function automatic int model_cpu(input logic we, input logic [AW-1:0] a,
                                    input logic [DW-1:0] wd, output logic [DW-1:0] rd);
      int ix = int'(a[IW-1:0]);
      logic [TW-1:0] tg = a[AW-1:IW];
      int cls = 0;
      if (!(mv[ix] && mt[ix] == tg)) begin
         cls = (mv[ix] && md[ix]) ? 2 : 1;
         if (cls == 2) emem[{mt[ix], a[IW-1:0]}] = mdat[ix];
         mv[ix] = 1'b1; md[ix] = 1'b0; mt[ix] = tg; mdat[ix] = emem[a];
      end
      if (we) begin mdat[ix] = wd; md[ix] = 1'b1; end
      rd = mdat[ix];
      return cls;
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic cpu_op(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                         output logic [DW-1:0] rd, output int cyc);
      @(negedge clk);
      cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd; cyc = 0;
      forever begin
         #1;
         if (cpu_ready) break;
         @(negedge clk);
         cyc++;
      end
      rd = cpu_rdata;
      @(posedge clk);
      #1 cpu_req = 1'b0; cpu_we = 1'b0;
   endtask

   // processor access with model expectation, latency checked
   task automatic cpu_check(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                            output int cls);
      logic [DW-1:0] erd, ard;
      int cyc, elat;
      string req;
      cls  = model_cpu(we, a, wd, erd);
      req  = (cls == 0) ? (we ? "R3" : "R2") : ((cls == 1) ? "R4" : "R5");
      elat = (cls == 0) ? 0 : ((cls == 1) ? 3 : 5);
      cpu_op(we, a, wd, ard, cyc);
      chk(req, cyc, elat);
      if (!we) chk(req, ard, erd);
   endtask

   task automatic dma_op(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] wd);
      int ix = int'(a[IW-1:0]);
      logic hit, dty;
      logic [DW-1:0] act;
      string req;
      @(posedge clk);
      dma_active = 1'b1;
      forever begin
         @(negedge clk);
         #1;
         if (!bus_grant) break;
      end
      hit = mv[ix] && mt[ix] == a[AW-1:IW];
      dty = hit && md[ix];
      if (we) req = !hit ? "R9" : (dty ? "R11" : "R10");
      else    req = dty ? "R8" : "R7";
      dma_cyc = 1'b1; dma_we = we; dma_addr = a; dma_wdata = wd;
      #1;
      chk(req, snoop_intervene, (!we && dty));
      if (!we) begin
         act = snoop_intervene ? snoop_data : mem[a];
         chk(req, act, dty ? mdat[ix] : emem[a]);
      end else begin
         emem[a] = wd;
         if (hit) begin mv[ix] = 1'b0; md[ix] = 1'b0; end
      end
      @(posedge clk);
      #1 dma_cyc = 1'b0; dma_we = 1'b0; dma_active = 1'b0;
   endtask

   initial begin
      #(4 * 150000);
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      int cls, cyc, w0;
      logic [DW-1:0] rd, erd;
      void'($urandom(32'd4242));
      for (int i = 0; i < NL; i++) begin mv[i] = 0; md[i] = 0; mt[i] = '0; mdat[i] = '0; end
      for (int i = 0; i < MW; i++) emem[i] = DW'(i * 37 + 5);
      repeat (4) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk); #1;
      // R1: reset state
      chk("R1", cpu_ready, 0);
      chk("R1", bus_req, 0);
      chk("R1", bus_cyc_o, 0);
      chk("R1", snoop_intervene, 0);
      dma_op(1'b0, 10'h005, '0);
      cls = model_cpu(1'b0, 10'h010, '0, erd);
      cpu_op(1'b0, 10'h010, '0, rd, cyc);
      chk("R1", cyc, 3);
      chk("R1", rd, erd);
      // R2 / R3 / R8
      cpu_check(1'b0, 10'h010, '0, cls);
      cpu_check(1'b1, 10'h010, 16'hBEEF, cls);
      cpu_check(1'b0, 10'h010, '0, cls);
      dma_op(1'b0, 10'h010, '0);
      // R5: dirty victim written back before refill
      cpu_check(1'b0, 10'h018, '0, cls);
      chk("R5", cls, 2);
      @(negedge clk);
      chk("R5", mem[10'h010], 16'hBEEF);
      // R9: DMA write miss leaves held line
      dma_op(1'b1, 10'h020, 16'h1234);
      cpu_op(1'b0, 10'h018, '0, rd, cyc);
      cls = model_cpu(1'b0, 10'h018, '0, erd);
      chk("R9", cyc, 0);
      // R10: DMA write to clean line purges it
      dma_op(1'b1, 10'h018, 16'h5A5A);
      cls = model_cpu(1'b0, 10'h018, '0, erd);
      cpu_op(1'b0, 10'h018, '0, rd, cyc);
      chk("R10", cyc, 3);
      chk("R10", rd, 16'h5A5A);
      // R11: dirty line purged, dirty word discarded
      cpu_check(1'b1, 10'h021, 16'hD00D, cls);
      w0 = wr_count;
      dma_op(1'b1, 10'h021, 16'h7777);
      cpu_check(1'b0, 10'h029, '0, cls);
      chk("R11", cls, 1);
      chk("R11", wr_count, w0);
      cpu_check(1'b0, 10'h021, '0, cls);
      cls = model_cpu(1'b0, 10'h021, '0, erd);
      chk("R11", erd, 16'h7777);
      cpu_check(1'b0, 10'h029, '0, cls);
      // R12: snoop hit and processor request in one cycle
      cpu_check(1'b0, 10'h018, '0, cls);
      cls = model_cpu(1'b0, 10'h029, '0, erd);
      @(posedge clk);
      dma_active = 1'b1;
      @(negedge clk);
      cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = 10'h029;
      dma_cyc = 1'b1; dma_we = 1'b0; dma_addr = 10'h018;
      #1;
      chk("R12", cpu_ready, 0);
      chk("R7", snoop_intervene, 0);
      @(posedge clk);
      #1 dma_cyc = 1'b0; dma_active = 1'b0;
      @(negedge clk); #1;
      chk("R12", cpu_ready, 1);
      chk("R12", cpu_rdata, erd);
      @(posedge clk);
      #1 cpu_req = 1'b0;
      // R13: dirty victim purged while waiting for the bus
      cpu_check(1'b1, 10'h012, 16'hCAFE, cls);
      w0 = wr_count;
      gnt_en = 1'b0;
      fork
         cpu_op(1'b0, 10'h01A, '0, rd, cyc);
         begin
            repeat (3) @(negedge clk);
            #1;
            chk("R6", bus_req, 1);
            chk("R6", bus_cyc_o, 0);
            chk("R6", bus_addr_o, 0);
            dma_op(1'b1, 10'h012, 16'h4321);
            gnt_en = 1'b1;
         end
      join
      cls = model_cpu(1'b0, 10'h01A, '0, erd);
      chk("R13", rd, erd);
      chk("R13", wr_count, w0);
      @(negedge clk);
      chk("R13", mem[10'h012], 16'h4321);
      // constrained random mix
      for (int n = 0; n < 400; n++) begin
         logic [AW-1:0] a = AW'($urandom_range(0, 47));
         logic [DW-1:0] d = DW'($urandom);
         int kind = $urandom_range(0, 9);
         if (kind < 4)      cpu_check(1'b0, a, '0, cls);
         else if (kind < 7) cpu_check(1'b1, a, d, cls);
         else if (kind < 9) dma_op(1'b0, a, '0);
         else               dma_op(1'b1, a, d);
      end
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule